// File: doc/BRIEF.md
# Bus Ownership Controller with CPU Reset Hold

This block takes ownership of a target processor's external bus and controls that processor's reset line. It drives an active-low bus request, watches an active-low bus grant, and drives the processor's active-low reset. A host gives it one command at a time: reset, request, release, run, restart and memory-cycle gap. It reports one of four states. Each state pairs "processor held in reset" or "processor running" with "bus owned" or "bus not owned".

The block turns on the output drivers of a neighbouring memory-cycle engine only while it owns the bus. A grant wait ends after a number of slow ticks. The ticks come from a prescaler that restarts when the wait begins. When the grant wait runs out, the block returns to the state it came from. A request made while the processor is held in reset lets the reset go for the length of the wait, because a processor in reset cannot grant its bus. The reset pulse length, the memory-cycle gap length, the prescaler ratio and the tick count of the timeout are all parameters.

Top module: `busown_ctrl`

## Requirements
- R1: After reset, and one clock after a reset command (code 0) in any state or phase, own_state is 0, cpu_reset_n is 0, cpu_busreq_n is 1, bus_drive_en is 0 and busy is 0. A reset command aborts any wait or pulse that is in progress.
- R2: A request (code 1) in state 0 drives cpu_busreq_n low and cpu_reset_n high. When cpu_busack_n goes low, the block enables bus_drive_en and enters state 1 with cpu_reset_n still high.
- R3: If the grant does not come, a request from state 0 stays busy for exactly TIMEOUT_TICKS*TICK_DIV+1 cycles. It then returns to state 0 with cpu_reset_n 0, cpu_busreq_n 1 and bus_drive_en 0.
- R4: A request in state 2 drives cpu_busreq_n low. On a grant it enters state 3 with bus_drive_en 1. On a timeout it stays in state 2 with cpu_busreq_n 1 and cpu_reset_n 1.
- R5: A release (code 2) in state 1 enters state 0 with cpu_reset_n 0. A release in state 3 enters state 2 with cpu_reset_n 1. Both set cpu_busreq_n to 1 and bus_drive_en to 0.
- R6: A run (code 3) in state 0 sets cpu_reset_n to 1 and enters state 2 with no reset pulse.
- R7: A run in state 1 holds bus_drive_en at 0 and cpu_reset_n at 0 for exactly PULSE_CYCLES cycles. It then enters state 3 with cpu_reset_n 1, cpu_busreq_n 0 and bus_drive_en 1.
- R8: A restart (code 4) in state 2 or 3 drives cpu_reset_n low for exactly PULSE_CYCLES cycles. The state and bus_drive_en do not change.
- R9: A memory-cycle gap (code 5) in state 3 turns bus_drive_en off and drives cpu_busreq_n high for exactly GAP_CYCLES cycles, then low again. It then waits for the grant and turns bus_drive_en back on when the grant arrives. The state stays 3.
- R10: The block ignores any command not listed above for the current state, and codes 6 and 7. While busy is 1, it ignores every command except reset.
- R11: bus_drive_en is 1 only while cpu_busreq_n is 0 and own_state is 1 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 3 | 0 reset, 1 request, 2 release, 3 run, 4 restart, 5 memory-cycle gap |
| cpu_busack_n | input | 1 | Processor bus grant, active low, synchronous to clk |
| cpu_busreq_n | output | 1 | Bus request to processor, active low |
| cpu_reset_n | output | 1 | Processor reset, active low |
| bus_drive_en | output | 1 | Enables the cycle engine's address, data and strobe drivers |
| own_state | output | 2 | 0 held, 1 held and owned, 2 running, 3 running and owned |
| busy | output | 1 | A grant wait, reset pulse or gap is in progress |

## Verification
Two functions can land in the same cycle: a reset command and a grant wait that is still in progress. The bench disables the modelled grant, issues a request from state 2 and sends a reset command a few cycles into the wait. It then judges that every output reaches its reset value one cycle later and that busy drops at once, instead of running on to a timeout. A restart sent while a wait is in progress is checked the same way, and cpu_reset_n must stay high for the whole wait.

// File: rtl/busown_pkg.sv
package busown_pkg;

    typedef enum logic [1:0] {
        ST_HELD       = 2'd0,
        ST_HELD_OWNED = 2'd1,
        ST_RUN        = 2'd2,
        ST_RUN_OWNED  = 2'd3
    } own_state_e;

    typedef enum logic [2:0] {
        CMD_RESET   = 3'd0,
        CMD_REQUEST = 3'd1,
        CMD_RELEASE = 3'd2,
        CMD_RUN     = 3'd3,
        CMD_RESTART = 3'd4,
        CMD_MCYCLE  = 3'd5
    } own_cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ACKWAIT = 3'd1,
        PH_PULSE   = 3'd2,
        PH_GAP     = 3'd3,
        PH_MWAIT   = 3'd4
    } own_phase_e;

endpackage

// File: rtl/busown_tick.sv
module busown_tick #(
    parameter int TICK_DIV = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        if (clear || tick) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/busown_timeout.sv
module busown_timeout #(
    parameter int TIMEOUT_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic expired
);
    localparam int W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [W-1:0] LOAD = W'(TIMEOUT_TICKS);

    logic [W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (start)                    cnt_d = LOAD;
        else if (tick && !expired)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: between restarts the remaining tick count never grows
    a_r3_count_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/busown_fsm.sv
module busown_fsm
    import busown_pkg::*;
#(
    parameter int PULSE_CYCLES = 1000,
    parameter int GAP_CYCLES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic       busack_n,
    input  logic       expired,
    output logic       start_wait,
    output logic       busreq_n,
    output logic       reset_n,
    output logic       drive_en,
    output logic [1:0] state,
    output logic       busy
);
    localparam int MAXC  = (PULSE_CYCLES > GAP_CYCLES) ? PULSE_CYCLES : GAP_CYCLES;
    localparam int CW    = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYCLES);
    localparam logic [CW-1:0] GAP_LD   = CW'(GAP_CYCLES);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        own_state_e    st;
        own_phase_e    ph;
        logic          busreq_n;
        logic          reset_n;
        logic          drive;
        logic [CW-1:0] cnt;
        own_state_e    tgt;
    } regs_t;

    regs_t    r_q, r_d;
    own_cmd_e cmd;
    logic     take;

    always_comb begin
        r_d        = r_q;
        start_wait = 1'b0;
        cmd        = own_cmd_e'(cmd_code);
        take       = cmd_valid && (r_q.ph == PH_IDLE);

        if (cmd_valid && cmd == CMD_RESET) begin
            r_d.st       = ST_HELD;
            r_d.ph       = PH_IDLE;
            r_d.busreq_n = 1'b1;
            r_d.reset_n  = 1'b0;
            r_d.drive    = 1'b0;
            r_d.cnt      = '0;
        end else begin
            unique case (r_q.ph)
                PH_IDLE: if (take) begin
                    case (cmd)
                        CMD_REQUEST: if (r_q.st == ST_HELD || r_q.st == ST_RUN) begin
                            r_d.busreq_n = 1'b0;
                            r_d.reset_n  = 1'b1;
                            r_d.ph       = PH_ACKWAIT;
                            start_wait   = 1'b1;
                        end
                        CMD_RELEASE: if (r_q.st == ST_HELD_OWNED || r_q.st == ST_RUN_OWNED) begin
                            r_d.drive    = 1'b0;
                            r_d.busreq_n = 1'b1;
                            r_d.reset_n  = (r_q.st == ST_RUN_OWNED);
                            r_d.st       = (r_q.st == ST_RUN_OWNED) ? ST_RUN : ST_HELD;
                        end
                        CMD_RUN: begin
                            if (r_q.st == ST_HELD) begin
                                r_d.reset_n = 1'b1;
                                r_d.st      = ST_RUN;
                            end else if (r_q.st == ST_HELD_OWNED) begin
                                r_d.drive   = 1'b0;
                                r_d.reset_n = 1'b0;
                                r_d.cnt     = PULSE_LD;
                                r_d.tgt     = ST_RUN_OWNED;
                                r_d.ph      = PH_PULSE;
                            end
                        end
                        CMD_RESTART: if (r_q.st == ST_RUN || r_q.st == ST_RUN_OWNED) begin
                            r_d.reset_n = 1'b0;
                            r_d.cnt     = PULSE_LD;
                            r_d.tgt     = r_q.st;
                            r_d.ph      = PH_PULSE;
                        end
                        CMD_MCYCLE: if (r_q.st == ST_RUN_OWNED) begin
                            r_d.drive    = 1'b0;
                            r_d.busreq_n = 1'b1;
                            r_d.cnt      = GAP_LD;
                            r_d.ph       = PH_GAP;
                        end
                        default: ;
                    endcase
                end
                PH_ACKWAIT: begin
                    if (!busack_n) begin
                        r_d.drive = 1'b1;
                        r_d.st    = (r_q.st == ST_HELD) ? ST_HELD_OWNED : ST_RUN_OWNED;
                        r_d.ph    = PH_IDLE;
                    end else if (expired) begin
                        r_d.busreq_n = 1'b1;
                        r_d.reset_n  = (r_q.st == ST_RUN);
                        r_d.ph       = PH_IDLE;
                    end
                end
                PH_PULSE: begin
                    if (r_q.cnt == ONE) begin
                        r_d.reset_n = 1'b1;
                        r_d.st      = r_q.tgt;
                        r_d.drive   = (r_q.tgt == ST_RUN_OWNED);
                        r_d.ph      = PH_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                PH_GAP: begin
                    if (r_q.cnt == ONE) begin
                        r_d.busreq_n = 1'b0;
                        r_d.ph       = PH_MWAIT;
                        start_wait   = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                PH_MWAIT: begin
                    if (!busack_n) begin
                        r_d.drive = 1'b1;
                        r_d.ph    = PH_IDLE;
                    end else if (expired) begin
                        r_d.ph = PH_IDLE;
                    end
                end
                default: r_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_HELD;
            r_q.ph       <= PH_IDLE;
            r_q.busreq_n <= 1'b1;
            r_q.reset_n  <= 1'b0;
            r_q.drive    <= 1'b0;
            r_q.cnt      <= '0;
            r_q.tgt      <= ST_RUN;
        end else begin
            r_q <= r_d;
        end
    end

    assign busreq_n = r_q.busreq_n;
    assign reset_n  = r_q.reset_n;
    assign drive_en = r_q.drive;
    assign state    = r_q.st;
    assign busy     = (r_q.ph != PH_IDLE);

    // R1: a reset command always lands in the held, unowned condition
    a_r1_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd0) |=>
            (state == 2'd0 && !reset_n && busreq_n && !drive_en && !busy));

    // R11: drivers on only while the bus is requested and owned
    a_r11_drive_owned: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (!busreq_n && state[0]));

    // R5: an idle held state keeps the processor in reset
    a_r5_held_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && !busy) |-> !reset_n);

    // R9: during the gap the request is withdrawn and the drivers are off
    a_r9_gap_released: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_GAP) |-> (busreq_n && !drive_en));

    // R10: a release with no bus owned changes nothing
    a_r10_release_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_code == 3'd2 && !state[0]) |=>
            ($stable(state) && $stable(reset_n) && $stable(busreq_n)));
endmodule

// File: rtl/busown_ctrl.sv
module busown_ctrl #(
    parameter int TICK_DIV      = 10_000_000,
    parameter int TIMEOUT_TICKS = 20,
    parameter int PULSE_CYCLES  = 1000,
    parameter int GAP_CYCLES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic       cpu_busack_n,
    output logic       cpu_busreq_n,
    output logic       cpu_reset_n,
    output logic       bus_drive_en,
    output logic [1:0] own_state,
    output logic       busy
);
    logic start_wait, tick, expired;

    busown_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_wait),
        .tick  (tick)
    );

    busown_timeout #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_wait),
        .tick    (tick),
        .expired (expired)
    );

    busown_fsm #(.PULSE_CYCLES(PULSE_CYCLES), .GAP_CYCLES(GAP_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .busack_n   (cpu_busack_n),
        .expired    (expired),
        .start_wait (start_wait),
        .busreq_n   (cpu_busreq_n),
        .reset_n    (cpu_reset_n),
        .drive_en   (bus_drive_en),
        .state      (own_state),
        .busy       (busy)
    );
endmodule

// File: tb/sim_busown_ctrl.sv
`timescale 1ns/1ps
module sim_busown_ctrl;
    localparam int DIV = 4;
    localparam int TT  = 3;
    localparam int PL  = 5;
    localparam int GP  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic cpu_busack_n;
    logic cpu_busreq_n, cpu_reset_n, bus_drive_en, busy;
    logic [1:0] own_state;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    busown_ctrl #(.TICK_DIV(DIV), .TIMEOUT_TICKS(TT), .PULSE_CYCLES(PL), .GAP_CYCLES(GP)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cpu_busack_n(cpu_busack_n), .cpu_busreq_n(cpu_busreq_n), .cpu_reset_n(cpu_reset_n),
        .bus_drive_en(bus_drive_en), .own_state(own_state), .busy(busy)
    );

    // processor model: grants after a delay while requested and enabled
    logic ack_en = 1'b1;
    int   dcnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_busack_n <= 1'b1;
            dcnt <= 0;
        end else if (cpu_busreq_n) begin
            cpu_busack_n <= 1'b1;
            dcnt <= 0;
        end else if (ack_en) begin
            if (dcnt >= 3) cpu_busack_n <= 1'b0;
            else           dcnt <= dcnt + 1;
        end
    end

    typedef struct {
        string tag;
        int st, rn, bq, dr;
    } exp_t;
    exp_t sb[$];

    // monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (int'(own_state) != e.st || int'(cpu_reset_n) != e.rn ||
                    int'(cpu_busreq_n) != e.bq || int'(bus_drive_en) != e.dr || busy) begin
                    errors++;
                    $display("FAIL %s: st/rst/req/drv/busy = %0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/0",
                             e.tag, own_state, cpu_reset_n, cpu_busreq_n, bus_drive_en, busy,
                             e.st, e.rn, e.bq, e.dr);
                end
            end
        end
    end

    task automatic expect_out(input string tag, input int st, input int rn, input int bq, input int dr);
        exp_t e;
        e.tag = tag; e.st = st; e.rn = rn; e.bq = bq; e.dr = dr;
        sb.push_back(e);
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    int nb, nr, nq, nd;

    task automatic do_cmd(input logic [2:0] code);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        nb = 0; nr = 0; nq = 0; nd = 0;
        while (busy && nb < 2000) begin
            nb++;
            if (!cpu_reset_n)  nr++;
            if (cpu_busreq_n)  nq++;
            if (!bus_drive_en) nd++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_out("R1 after reset", 0, 0, 1, 0);

        do_cmd(3'd2);
        expect_out("R10 release in state 0 ignored", 0, 0, 1, 0);

        do_cmd(3'd1);
        expect_out("R2 request from held with grant", 1, 1, 0, 1);
        do_cmd(3'd1);
        expect_out("R10 request in state 1 ignored", 1, 1, 0, 1);
        do_cmd(3'd2);
        expect_out("R5 release from state 1", 0, 0, 1, 0);

        ack_en = 1'b0;
        do_cmd(3'd1);
        chk("R3 timeout busy length", nb, TT*DIV + 1);
        chk("R3 reset released during wait", nr, 0);
        expect_out("R3 timeout from held", 0, 0, 1, 0);
        ack_en = 1'b1;

        do_cmd(3'd6);
        do_cmd(3'd7);
        expect_out("R10 codes 6 and 7 ignored", 0, 0, 1, 0);

        do_cmd(3'd3);
        chk("R6 no busy time on run from held", nb, 0);
        expect_out("R6 run from held", 2, 1, 1, 0);
        do_cmd(3'd3);
        do_cmd(3'd5);
        expect_out("R10 run and gap in state 2 ignored", 2, 1, 1, 0);

        do_cmd(3'd4);
        chk("R8 restart pulse in state 2", nr, PL);
        expect_out("R8 state kept after restart in 2", 2, 1, 1, 0);

        ack_en = 1'b0;
        do_cmd(3'd1);
        chk("R4 timeout keeps reset high", nr, 0);
        expect_out("R4 timeout from running", 2, 1, 1, 0);
        ack_en = 1'b1;

        do_cmd(3'd1);
        expect_out("R4 request from running with grant", 3, 1, 0, 1);

        do_cmd(3'd4);
        chk("R8 restart pulse in state 3", nr, PL);
        chk("R8 drivers stay on during restart", nd, 0);
        expect_out("R8 state kept after restart in 3", 3, 1, 0, 1);

        do_cmd(3'd5);
        chk("R9 request withdrawn for gap length", nq, GP);
        expect_out("R9 gap ends owned", 3, 1, 0, 1);

        do_cmd(3'd2);
        expect_out("R5 release from state 3", 2, 1, 1, 0);

        do_cmd(3'd0);
        expect_out("R1 reset command from running", 0, 0, 1, 0);
        do_cmd(3'd1);
        expect_out("R2 request from held again", 1, 1, 0, 1);
        do_cmd(3'd3);
        chk("R7 reset pulse on run from state 1", nr, PL);
        chk("R7 drivers off during pulse", nd, PL);
        expect_out("R7 run from held-owned", 3, 1, 0, 1);

        do_cmd(3'd2);
        expect_out("R5 release to running", 2, 1, 1, 0);
        ack_en = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'd4;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10 restart while busy leaves reset high", int'(cpu_reset_n), 1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R1 reset command aborts wait busy", int'(busy), 0);
        expect_out("R1 reset command during wait", 0, 0, 1, 0);
        ack_en = 1'b1;

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule